// File: doc/BRIEF.md
# Dual-Channel DAC Serial Control Front End

This block is the digital command side of a two-channel, 12-bit converter. A host drives a three-wire serial port: an active-low select, a serial clock and a data line. It may also read a fourth line, DOUT. DOUT is the tail of the internal 16-bit shift register. It can be looped back to the host for readback, or wired to the data input of the next device so that several devices form a chain. All port inputs are brought into the system clock domain through synchronizer chains. Serial clock edges are then found by comparing successive synchronized samples.

A complete frame is executed when select is released. A frame can load a per-channel input register, transfer both input registers into the DAC registers, set a general-purpose logic output, enter or leave software shutdown, or choose the serial clock edge on which DOUT changes. An active-low lockout input blocks software shutdown. When lockout falls during shutdown, the part wakes and both DAC codes are kept. The two DAC codes, the shutdown flag and the logic output go to the analog section, which is not part of this block.

Top module: `dual_dac_ctrl`

## Requirements
- R1: DIN is sampled on each rising serial clock edge while `cs_n` is low. When `cs_n` rises after 16 or more such edges, the last 16 bits are executed. Frame bit 15, the first of those 16 bits, is the command MSB. Bits 15:13 are the command, bits 12:1 are the 12-bit code with D11 at bit 12, and bit 0 is a sub bit that is ignored.
- R2: Commands 000 and 001 load the input register of channel A and channel B respectively. Both DAC outputs stay unchanged.
- R3: Command 010 loads input A and command 011 loads input B. In the same step, both DAC registers take their channel's input value, with the new code used for the loaded channel.
- R4: Command 100 copies both input registers into the DAC registers. Its code field is ignored.
- R5: Command 101 sets `upo_o` to D11. `upo_o` is low after reset.
- R6: Command 110 sets the shutdown flag to D11 while `lock_n` is high. While `lock_n` is low, this command has no effect and `shdn_o` stays low.
- R7: A high-to-low transition of `lock_n` during shutdown clears `shdn_o`. Both DAC codes keep the values they held before the transition.
- R8: Command 111 with D11=1 selects DOUT mode D10, where 0 is falling-edge mode and 1 is rising-edge mode. Command 111 with D11=0 is a no-op. After reset the mode is falling-edge mode.
- R9: A frame with fewer than 16 rising serial clock edges is discarded and changes no output.
- R10: In falling-edge mode, DOUT changes only on falling serial clock edges while selected. It then shows the bit that is 16 positions back in the serial stream.
- R11: In rising-edge mode, DOUT follows the shift register tail directly. The bit that is 16 positions back appears right after each rising edge, half a serial clock earlier than in falling-edge mode.
- R12: After reset, both DAC codes are zero and `shdn_o`, `upo_o` and `dout` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial data in |
| lock_n | input | 1 | Shutdown lockout, active low |
| dout | output | 1 | Serial data out for readback or chaining |
| dac_a_o | output | 12 | Channel A DAC code |
| dac_b_o | output | 12 | Channel B DAC code |
| shdn_o | output | 1 | Software shutdown status |
| upo_o | output | 1 | User logic output |

## Verification
The hardest behaviour to expose is the half-cycle offset between the two DOUT modes. The bench reaches it with a second frame sent right after a known load frame, so the shift register still holds the previous word. DOUT is sampled both after each rising edge and after each falling edge. In falling-edge mode the value seen after a rising edge must still be the previous bit. The same readback runs once in each mode. Before the mode is changed, a no-op mode command is sent, and the falling-edge readback that follows confirms it had no effect.

// File: rtl/dual_dac_pkg.sv
package dual_dac_pkg;
  localparam int FRAME_W = 16;
  localparam int CODE_W  = 12;
  localparam int CMD_W   = 3;
  localparam int CNT_W   = $clog2(FRAME_W) + 1;

  typedef enum logic [CMD_W-1:0] {
    CMD_LD_A   = 3'd0,
    CMD_LD_B   = 3'd1,
    CMD_LDUP_A = 3'd2,
    CMD_LDUP_B = 3'd3,
    CMD_UPD    = 3'd4,
    CMD_UPO    = 3'd5,
    CMD_SHDN   = 3'd6,
    CMD_MISC   = 3'd7
  } cmd_e;

  typedef struct packed {
    cmd_e              cmd;
    logic [CODE_W-1:0] code;
    logic              sub;
  } frame_t;
endpackage

// File: rtl/dual_dac_sync.sv
module dual_dac_sync #(
  parameter int              WIDTH   = 4,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb chain_d = {chain_q[STAGES-2:0], d_i[g]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL[g]}};
      else        chain_q <= chain_d;
    end

    assign q_o[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/dual_dac_shifter.sv
module dual_dac_shifter
  import dual_dac_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sclk_s,
  input  logic   cs_n_s,
  input  logic   din_s,
  input  logic   mode1_i,
  output logic   frame_vld_o,
  output frame_t frame_o,
  output logic   dout_o
);
  logic               sclk_q, sclk_d;
  logic               cs_q, cs_d;
  logic [FRAME_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               tail_q, tail_d;
  logic               sclk_rise, sclk_fall, cs_fall, cs_rise;

  always_comb begin
    sclk_rise = sclk_s & ~sclk_q;
    sclk_fall = ~sclk_s & sclk_q;
    cs_fall   = ~cs_n_s & cs_q;
    cs_rise   = cs_n_s & ~cs_q;
  end

  always_comb begin
    sclk_d = sclk_s;
    cs_d   = cs_n_s;
    sr_d   = sr_q;
    cnt_d  = cnt_q;
    tail_d = tail_q;
    if (cs_fall) cnt_d = '0;
    if (sclk_rise && !cs_n_s) begin
      sr_d = {sr_q[FRAME_W-2:0], din_s};
      if (cnt_q != CNT_W'(FRAME_W)) cnt_d = cnt_q + 1'b1;
    end
    if (sclk_fall && !cs_n_s) tail_d = sr_q[FRAME_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      sr_q   <= '0;
      cnt_q  <= '0;
      tail_q <= 1'b0;
    end else begin
      sclk_q <= sclk_d;
      cs_q   <= cs_d;
      sr_q   <= sr_d;
      cnt_q  <= cnt_d;
      tail_q <= tail_d;
    end
  end

  assign frame_vld_o = cs_rise && (cnt_q == CNT_W'(FRAME_W));
  assign frame_o     = frame_t'(sr_q);
  assign dout_o      = mode1_i ? sr_q[FRAME_W-1] : tail_q;
endmodule

// File: rtl/dual_dac_regs.sv
module dual_dac_regs
  import dual_dac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_vld_i,
  input  frame_t            frame_i,
  input  logic              lock_n_s,
  output logic [CODE_W-1:0] dac_a_o,
  output logic [CODE_W-1:0] dac_b_o,
  output logic              shdn_o,
  output logic              upo_o,
  output logic              mode1_o
);
  logic [CODE_W-1:0] in_a_q, in_a_d, in_b_q, in_b_d;
  logic [CODE_W-1:0] dac_a_q, dac_a_d, dac_b_q, dac_b_d;
  logic              shdn_q, shdn_d, upo_q, upo_d, mode_q, mode_d;
  logic [CODE_W-1:0] code;

  assign code = frame_i.code;

  always_comb begin
    in_a_d  = in_a_q;
    in_b_d  = in_b_q;
    dac_a_d = dac_a_q;
    dac_b_d = dac_b_q;
    shdn_d  = shdn_q;
    upo_d   = upo_q;
    mode_d  = mode_q;
    if (frame_vld_i) begin
      unique case (frame_i.cmd)
        CMD_LD_A: in_a_d = code;
        CMD_LD_B: in_b_d = code;
        CMD_LDUP_A: begin
          in_a_d  = code;
          dac_a_d = code;
          dac_b_d = in_b_q;
        end
        CMD_LDUP_B: begin
          in_b_d  = code;
          dac_b_d = code;
          dac_a_d = in_a_q;
        end
        CMD_UPD: begin
          dac_a_d = in_a_q;
          dac_b_d = in_b_q;
        end
        CMD_UPO:  upo_d = code[CODE_W-1];
        CMD_SHDN: if (lock_n_s) shdn_d = code[CODE_W-1];
        CMD_MISC: if (code[CODE_W-1]) mode_d = code[CODE_W-2];
        default: ;
      endcase
    end
    if (!lock_n_s) shdn_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_a_q  <= '0;
      in_b_q  <= '0;
      dac_a_q <= '0;
      dac_b_q <= '0;
      shdn_q  <= 1'b0;
      upo_q   <= 1'b0;
      mode_q  <= 1'b0;
    end else begin
      in_a_q  <= in_a_d;
      in_b_q  <= in_b_d;
      dac_a_q <= dac_a_d;
      dac_b_q <= dac_b_d;
      shdn_q  <= shdn_d;
      upo_q   <= upo_d;
      mode_q  <= mode_d;
    end
  end

  assign dac_a_o = dac_a_q;
  assign dac_b_o = dac_b_q;
  assign shdn_o  = shdn_q;
  assign upo_o   = upo_q;
  assign mode1_o = mode_q;
endmodule

// File: rtl/dual_dac_ctrl.sv
module dual_dac_ctrl
  import dual_dac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  input  logic              lock_n,
  output logic              dout,
  output logic [CODE_W-1:0] dac_a_o,
  output logic [CODE_W-1:0] dac_b_o,
  output logic              shdn_o,
  output logic              upo_o
);
  logic       rst_meta_q, rst_sync_n;
  logic [3:0] pins_s;
  logic       sclk_s, cs_n_s, din_s, lock_s;
  logic       frame_vld, mode1;
  frame_t     frame;

  // Reset asserts at once and is released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  dual_dac_sync #(
    .WIDTH  (4),
    .STAGES (SYNC_STAGES),
    .RST_VAL(4'b1010)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .d_i  ({lock_n, sclk, cs_n, din}),
    .q_o  (pins_s)
  );

  assign {lock_s, sclk_s, cs_n_s, din_s} = pins_s;

  dual_dac_shifter u_shift (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .sclk_s     (sclk_s),
    .cs_n_s     (cs_n_s),
    .din_s      (din_s),
    .mode1_i    (mode1),
    .frame_vld_o(frame_vld),
    .frame_o    (frame),
    .dout_o     (dout)
  );

  dual_dac_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .frame_vld_i(frame_vld),
    .frame_i    (frame),
    .lock_n_s   (lock_s),
    .dac_a_o    (dac_a_o),
    .dac_b_o    (dac_b_o),
    .shdn_o     (shdn_o),
    .upo_o      (upo_o),
    .mode1_o    (mode1)
  );
endmodule

// File: rtl/dual_dac_ctrl_chk.sv
module dual_dac_ctrl_chk
  import dual_dac_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              frame_vld,
  input frame_t            frame,
  input logic              lock_s,
  input logic              mode1,
  input logic [CODE_W-1:0] dac_a_o,
  input logic [CODE_W-1:0] dac_b_o,
  input logic              shdn_o,
  input logic              upo_o
);
  // R6 / R7: lockout low keeps shutdown clear
  a_r6_lock_blocks_shdn: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_s |=> !shdn_o);

  // R9: DAC codes move only on an executed frame
  a_r9_dac_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_vld |=> ($stable(dac_a_o) && $stable(dac_b_o)));

  // R2: input-only loads leave the DAC codes alone
  a_r2_load_only: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && (frame.cmd == CMD_LD_A || frame.cmd == CMD_LD_B))
      |=> ($stable(dac_a_o) && $stable(dac_b_o)));

  // R5: user output changes only through its own command
  a_r5_upo_cmd_only: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_vld && frame.cmd == CMD_UPO) |=> $stable(upo_o));

  // R8: mode changes only through a command 111 with D11 set
  a_r8_mode_cmd_only: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_vld && frame.cmd == CMD_MISC && frame.code[CODE_W-1]) |=> $stable(mode1));
endmodule

bind dual_dac_ctrl dual_dac_ctrl_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .frame_vld(frame_vld),
  .frame    (frame),
  .lock_s   (lock_s),
  .mode1    (mode1),
  .dac_a_o  (dac_a_o),
  .dac_b_o  (dac_b_o),
  .shdn_o   (shdn_o),
  .upo_o    (upo_o)
);

// File: tb/dual_dac_ctrl_tb.sv
module dual_dac_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, sclk = 1'b0, din = 1'b0, lock_n = 1'b1;
  logic        dout, shdn_o, upo_o;
  logic [11:0] dac_a_o, dac_b_o;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  dual_dac_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .lock_n(lock_n), .dout(dout), .dac_a_o(dac_a_o), .dac_b_o(dac_b_o),
    .shdn_o(shdn_o), .upo_o(upo_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] mk(logic [2:0] cmd, logic [11:0] code);
    return {cmd, code, 1'b0};
  endfunction

  task automatic send(logic [31:0] w, int nbits);
    cs_n = 1'b0; waitc(8);
    for (int i = nbits - 1; i >= 0; i--) begin
      din = w[i]; waitc(8);
      sclk = 1'b1; waitc(8);
      sclk = 1'b0;
    end
    waitc(8); cs_n = 1'b1; waitc(10);
  endtask

  // Second frame after a known word; word x is observed on dout.
  task automatic readback(logic [15:0] x, logic m1, string req);
    logic [15:0] nop;
    nop = mk(3'b111, 12'h000);
    cs_n = 1'b0; waitc(8);
    for (int i = 1; i <= 16; i++) begin
      din = nop[16-i]; waitc(8);
      sclk = 1'b1; waitc(5);
      if (i <= 15) check(req, dout, m1 ? x[15-i] : x[16-i]);
      waitc(3);
      sclk = 1'b0; waitc(5);
      if (i <= 15) check(req, dout, x[15-i]);
    end
    waitc(8); cs_n = 1'b1; waitc(10);
  endtask

  task automatic t_reset;
    check("R12 dac_a", dac_a_o, 0);
    check("R12 dac_b", dac_b_o, 0);
    check("R12 shdn", shdn_o, 0);
    check("R12 upo", upo_o, 0);
    check("R12 dout", dout, 0);
  endtask

  task automatic t_loads;
    send(mk(3'b000, 12'hABC), 16);
    check("R2 load A only", dac_a_o, 0);
    send(mk(3'b001, 12'h123), 16);
    check("R2 load B only", dac_b_o, 0);
    send(mk(3'b100, 12'hFFF), 16);
    check("R4 update A", dac_a_o, 12'hABC);
    check("R4 update B", dac_b_o, 12'h123);
    send(mk(3'b011, 12'h456), 16);
    check("R3 ldup B", dac_b_o, 12'h456);
    check("R3 ldup B keeps A", dac_a_o, 12'hABC);
    send(mk(3'b000, 12'h777), 16);
    send(mk(3'b010, 12'h321), 16);
    check("R3 ldup A", dac_a_o, 12'h321);
    check("R3 ldup A other", dac_b_o, 12'h456);
  endtask

  task automatic t_frames;
    send({16'h0, mk(3'b010, 12'h999)} >> 4, 12);
    check("R9 short frame A", dac_a_o, 12'h321);
    check("R9 short frame B", dac_b_o, 12'h456);
    send({16'h000F, mk(3'b010, 12'h5A5)} , 20);
    check("R1 long frame last16", dac_a_o, 12'h5A5);
    send(mk(3'b010, 12'h5A5) | 16'h1, 16);
    check("R1 sub bit ignored", dac_a_o, 12'h5A5);
  endtask

  task automatic t_upo;
    send(mk(3'b101, 12'h800), 16);
    check("R5 upo high", upo_o, 1);
    send(mk(3'b101, 12'h7FF), 16);
    check("R5 upo low", upo_o, 0);
  endtask

  task automatic t_shdn;
    send(mk(3'b110, 12'h800), 16);
    check("R6 shutdown set", shdn_o, 1);
    lock_n = 1'b0; waitc(6);
    check("R7 lockout wakes", shdn_o, 0);
    check("R7 code A kept", dac_a_o, 12'h5A5);
    check("R7 code B kept", dac_b_o, 12'h456);
    send(mk(3'b110, 12'h800), 16);
    check("R6 shutdown ignored", shdn_o, 0);
    lock_n = 1'b1; waitc(6);
    check("R6 still awake", shdn_o, 0);
    send(mk(3'b110, 12'h800), 16);
    send(mk(3'b110, 12'h000), 16);
    check("R6 shutdown leave", shdn_o, 0);
  endtask

  task automatic t_dout;
    logic [15:0] x;
    send(mk(3'b111, 12'h400), 16);
    x = mk(3'b000, 12'hC3A);
    send(x, 16);
    readback(x, 1'b0, "R8 R10 mode0 dout");
    send(mk(3'b111, 12'hC00), 16);
    x = mk(3'b001, 12'h2D6);
    send(x, 16);
    readback(x, 1'b1, "R8 R11 mode1 dout");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    waitc(4); rst_n = 1'b1; waitc(6);
    t_reset();
    t_loads();
    t_frames();
    t_upo();
    t_shdn();
    t_dout();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule